// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router takes four level-sensitive PCI interrupt lines and steers each one onto one of sixteen ISA interrupt request outputs. Every PCI line has a byte-wide routing register. The low nibble of the register names the ISA IRQ number. The top bit of the register switches the line off. Each ISA output is the OR of every enabled PCI line that currently selects it. Any number of PCI lines can therefore share one ISA output.

The routing registers sit at four consecutive byte offsets, starting at 0x60. One register belongs to each line, in line order. A byte-wide port writes and reads them. The outputs are a combinational function of the present inputs and the stored routing. A write therefore changes the routing from the next cycle on.

A separate swizzle path turns a device slot number and its interrupt pin into a PCI line index. System integration logic uses it to decide which line a device drives.

Top module: `irq_router`

## Requirements
- R1: While rst_ni is low, the routing registers hold 0x0A, 0x0A, 0x0B and 0x0B for lines 0, 1, 2 and 3. Writes are not accepted while rst_ni is low.
- R2: A write with cfg_we_i high to offset 0x60+n (n = 0..3) stores cfg_wdata_i in the register of line n. A later read of that offset returns the full stored byte.
- R3: A write to any offset outside 0x60..0x63 leaves all four registers unchanged, and it leaves all outputs unchanged.
- R4: cfg_rdata_o is 0x00 whenever cfg_addr_i is outside 0x60..0x63.
- R5: isa_irq_o[k] is high exactly when some line n has pci_irq_i[n] high, bit 7 of its register clear, and bits 3:0 of its register equal to k.
- R6: A line whose register has bit 7 set drives no ISA output, whatever its input level.
- R7: A routing write is visible on isa_irq_o in the cycle after the write edge, with pci_irq_i held constant.
- R8: For swz_slot_i in 18..21, swz_line_o = ((swz_slot_i - 18) + swz_pin_i) mod 4, where pin 0..3 means INTA..INTD.
- R9: For swz_slot_i outside 18..21, swz_line_o equals swz_pin_i.
- R10: When several active lines select the same IRQ number, that one output is high and no other output is driven by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data for cfg_addr_i |
| pci_irq_i | input | 4 | PCI interrupt levels, lines A..D |
| isa_irq_o | output | 16 | ISA interrupt request levels |
| swz_slot_i | input | 5 | Device slot number |
| swz_pin_i | input | 2 | Device interrupt pin, 0..3 = INTA..INTD |
| swz_line_o | output | 2 | PCI line used by that slot and pin |

## Verification
The bench builds the router with its default parameters: four lines, sixteen IRQs, an 8-bit offset, base offset 0x60 and swizzled slots starting at 18. These values let a full sweep of every slot and pin run in 128 cycles. A pseudo-random write stream aimed at offsets 0x5E..0x65 hits both edges of the register window. Register values with stray bits in 6:4 show that those bits are stored and read back but do not touch the IRQ select.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int BYTE_W  = 8;
  localparam int DIS_BIT = 7;
  typedef logic [BYTE_W-1:0] cfg_byte_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 8,
  parameter int CFG_BASE  = 'h60,
  parameter logic [NUM_LINES*BYTE_W-1:0] RST_ROUTE = 32'h0B0B_0A0A
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  cfg_byte_t                  wdata_i,
  output cfg_byte_t                  rdata_o,
  output logic [NUM_LINES-1:0]       line_en_o,
  output logic [NUM_LINES*SEL_W-1:0] line_sel_o
);
  logic [NUM_LINES-1:0] hit;
  cfg_byte_t            q [NUM_LINES];

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign hit[n] = (addr_i == ADDR_W'(CFG_BASE + n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             q[n] <= RST_ROUTE[n*BYTE_W +: BYTE_W];
      else if (we_i && hit[n]) q[n] <= wdata_i;
    end

    assign line_en_o[n]                 = ~q[n][DIS_BIT];
    assign line_sel_o[n*SEL_W +: SEL_W] = q[n][SEL_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_LINES; n++)
      if (hit[n]) rdata_o = q[n];
  end
endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin #(
  parameter int NUM_LINES = 4,
  parameter int NUM_IRQ   = 16,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_LINES-1:0]       pci_i,
  input  logic [NUM_LINES-1:0]       en_i,
  input  logic [NUM_LINES*SEL_W-1:0] sel_i,
  output logic [NUM_IRQ-1:0]         irq_o
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    logic [NUM_LINES-1:0] match;
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_src
      assign match[n] = pci_i[n] & en_i[n] & (sel_i[n*SEL_W +: SEL_W] == SEL_W'(k));
    end
    // wired-OR of every line steered here
    assign irq_o[k] = |match;
  end
endmodule

// File: rtl/irq_slot_swizzle.sv
module irq_slot_swizzle #(
  parameter int SLOT_W    = 5,
  parameter int LINE_W    = 2,
  parameter int NUM_LINES = 4,
  parameter int SWZ_FIRST = 18
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [LINE_W-1:0] pin_i,
  output logic [LINE_W-1:0] line_o
);
  logic              in_win;
  logic [SLOT_W-1:0] rel;

  assign in_win = (slot_i >= SLOT_W'(SWZ_FIRST)) &&
                  (slot_i <= SLOT_W'(SWZ_FIRST + NUM_LINES - 1));
  assign rel    = slot_i - SLOT_W'(SWZ_FIRST);
  // modulo NUM_LINES through truncation (power of two)
  assign line_o = in_win ? (rel[LINE_W-1:0] + pin_i) : pin_i;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_IRQ   = 16,
  parameter int ADDR_W    = 8,
  parameter int CFG_BASE  = 'h60,
  parameter int SLOT_W    = 5,
  parameter int SWZ_FIRST = 18,
  parameter logic [NUM_LINES*BYTE_W-1:0] RST_ROUTE = 32'h0B0B_0A0A,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int SEL_W  = $clog2(NUM_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  output logic [BYTE_W-1:0] cfg_rdata_o,
  input  logic [NUM_LINES-1:0] pci_irq_i,
  output logic [NUM_IRQ-1:0]   isa_irq_o,
  input  logic [SLOT_W-1:0] swz_slot_i,
  input  logic [LINE_W-1:0] swz_pin_i,
  output logic [LINE_W-1:0] swz_line_o
);
  logic [NUM_LINES-1:0]       line_en;
  logic [NUM_LINES*SEL_W-1:0] line_sel;

  irq_route_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .CFG_BASE(CFG_BASE), .RST_ROUTE(RST_ROUTE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .line_en_o(line_en), .line_sel_o(line_sel)
  );

  irq_route_fanin #(
    .NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)
  ) u_fanin (
    .pci_i(pci_irq_i), .en_i(line_en), .sel_i(line_sel), .irq_o(isa_irq_o)
  );

  irq_slot_swizzle #(
    .SLOT_W(SLOT_W), .LINE_W(LINE_W), .NUM_LINES(NUM_LINES), .SWZ_FIRST(SWZ_FIRST)
  ) u_swz (
    .slot_i(swz_slot_i), .pin_i(swz_pin_i), .line_o(swz_line_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_LINES = 4,
  parameter int NUM_IRQ   = 16,
  parameter int ADDR_W    = 8,
  parameter int CFG_BASE  = 'h60,
  parameter int SLOT_W    = 5,
  parameter int SWZ_FIRST = 18,
  parameter int LINE_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [7:0]        cfg_wdata_i,
  input logic [7:0]        cfg_rdata_o,
  input logic [NUM_LINES-1:0] pci_irq_i,
  input logic [NUM_IRQ-1:0]   isa_irq_o,
  input logic [SLOT_W-1:0] swz_slot_i,
  input logic [LINE_W-1:0] swz_pin_i,
  input logic [LINE_W-1:0] swz_line_o
);
  logic in_rng, slot_win;
  assign in_rng   = (cfg_addr_i >= ADDR_W'(CFG_BASE)) &&
                    (cfg_addr_i <= ADDR_W'(CFG_BASE + NUM_LINES - 1));
  assign slot_win = (swz_slot_i >= SLOT_W'(SWZ_FIRST)) &&
                    (swz_slot_i <= SLOT_W'(SWZ_FIRST + NUM_LINES - 1));

  a_r1_reset_line_a: assert property (@(posedge clk_i)
    (!rst_ni && cfg_addr_i == ADDR_W'(CFG_BASE)) |-> cfg_rdata_o == 8'h0A);

  a_r2_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && in_rng) ##1 (cfg_addr_i == $past(cfg_addr_i)) |-> cfg_rdata_o == $past(cfg_wdata_i));

  a_r4_outside_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rng |-> cfg_rdata_o == 8'h00);

  a_r5_quiet_inputs_quiet_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_irq_i == '0) |-> (isa_irq_o == '0));

  a_r10_no_output_fanout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isa_irq_o) <= $countones(pci_irq_i));

  a_r8_swizzled_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_win |-> swz_line_o == LINE_W'(int'(swz_slot_i) - SWZ_FIRST + int'(swz_pin_i)));

  a_r9_plain_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_win |-> swz_line_o == swz_pin_i);
endmodule

bind irq_router irq_router_chk #(
  .NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE),
  .SLOT_W(SLOT_W), .SWZ_FIRST(SWZ_FIRST), .LINE_W(LINE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .pci_irq_i(pci_irq_i),
  .isa_irq_o(isa_irq_o), .swz_slot_i(swz_slot_i), .swz_pin_i(swz_pin_i),
  .swz_line_o(swz_line_o)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic [3:0]  pci_irq_i = '0;
  logic [15:0] isa_irq_o;
  logic [4:0]  swz_slot_i = '0;
  logic [1:0]  swz_pin_i = '0;
  logic [1:0]  swz_line_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mreg [4];
  logic [15:0] lf = 16'hACE1;

  always #10ns clk = ~clk;

  irq_router u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .pci_irq_i(pci_irq_i),
    .isa_irq_o(isa_irq_o), .swz_slot_i(swz_slot_i), .swz_pin_i(swz_pin_i),
    .swz_line_o(swz_line_o)
  );

  function automatic logic [15:0] exp_isa();
    logic [15:0] o = '0;
    for (int i = 0; i < 4; i++)
      if (!mreg[i][7] && pci_irq_i[i]) o[mreg[i][3:0]] = 1'b1;
    return o;
  endfunction

  function automatic logic [7:0] exp_rd();
    int off = int'(cfg_addr_i) - 'h60;
    if (off >= 0 && off < 4) return mreg[off];
    return 8'h00;
  endfunction

  function automatic logic [1:0] exp_line();
    int s = int'(swz_slot_i);
    if (s >= 18 && s <= 21) return 2'((s - 18 + int'(swz_pin_i)) % 4);
    return swz_pin_i;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive, compare combinational outputs, then clock the model
  task automatic step(string tag, logic we, logic [7:0] a, logic [7:0] d, logic [3:0] p);
    int off;
    cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = d; pci_irq_i = p;
    #1ns;
    chk(tag, "isa_irq_o", 32'(isa_irq_o), 32'(exp_isa()));
    chk((a >= 8'h60 && a <= 8'h63) ? tag : "R4", "cfg_rdata_o", 32'(cfg_rdata_o), 32'(exp_rd()));
    chk((swz_slot_i >= 18 && swz_slot_i <= 21) ? "R8" : "R9", "swz_line_o",
        32'(swz_line_o), 32'(exp_line()));
    @(posedge clk);
    off = int'(a) - 'h60;
    if (we && rst_ni && off >= 0 && off < 4) mreg[off] = d;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20ns);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mreg[0] = 8'h0A; mreg[1] = 8'h0A; mreg[2] = 8'h0B; mreg[3] = 8'h0B;
    #1ns rst_ni = 1'b0;
    #1ns;
    // R1: reset values, write ignored during reset
    for (int i = 0; i < 4; i++) step("R1", 1'b0, 8'(8'h60 + i), 8'h00, 4'hF);
    step("R1", 1'b1, 8'h60, 8'hFF, 4'h1);
    step("R1", 1'b0, 8'h60, 8'h00, 4'h1);
    @(negedge clk);
    rst_ni = 1'b1;
    // R5: each line alone, then all
    for (int i = 0; i < 4; i++) step("R5", 1'b0, 8'h60, 8'h00, 4'(1 << i));
    step("R5", 1'b0, 8'h61, 8'h00, 4'hF);
    step("R5", 1'b0, 8'h62, 8'h00, 4'h0);
    // R2 + R7: route line 0 to IRQ 3 with input held
    step("R2", 1'b1, 8'h60, 8'h03, 4'h1);
    step("R7", 1'b0, 8'h60, 8'h00, 4'h1);
    step("R2", 1'b1, 8'h62, 8'h7E, 4'h5);
    step("R2", 1'b0, 8'h62, 8'h00, 4'h5);
    // R6: disable line 3, stray selected IRQ
    step("R6", 1'b1, 8'h63, 8'h87, 4'h8);
    step("R6", 1'b0, 8'h63, 8'h00, 4'h8);
    step("R6", 1'b0, 8'h63, 8'h00, 4'hF);
    // R3: writes outside the window
    step("R3", 1'b1, 8'h5F, 8'h01, 4'hF);
    step("R3", 1'b1, 8'h64, 8'h02, 4'hF);
    step("R3", 1'b1, 8'hFF, 8'h03, 4'hF);
    step("R3", 1'b1, 8'h00, 8'h04, 4'hF);
    for (int i = 0; i < 4; i++) step("R3", 1'b0, 8'(8'h60 + i), 8'h00, 4'hF);
    // R4: reads outside the window
    step("R4", 1'b0, 8'h10, 8'h00, 4'h0);
    step("R4", 1'b0, 8'h5F, 8'h00, 4'h0);
    // R10: all four lines share IRQ 5
    for (int i = 0; i < 4; i++) step("R10", 1'b1, 8'(8'h60 + i), 8'h05, 4'h0);
    for (int i = 0; i < 16; i++) step("R10", 1'b0, 8'h61, 8'h00, 4'(i));
    // R8, R9: full slot and pin sweep
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        swz_slot_i = 5'(s); swz_pin_i = 2'(p);
        step("R5", 1'b0, 8'h63, 8'h00, 4'h3);
      end
    // mixed stream around the window edges
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      swz_slot_i = lf[12:8]; swz_pin_i = lf[14:13];
      step("R2", lf[0], 8'(8'h5E + lf[3:1]), lf[15:8], lf[7:4]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule